// File: doc/BRIEF.md
# Serial Target Port with Preloaded Reply Byte

This block is the target (slave) side of a four-wire serial peripheral link, placed on an on-chip register bus. An external controller owns the bus clock, the data line toward the target and an active-low select line; the block drives the reply line back and an output enable for that line. Software writes the reply byte into a single data register before the controller starts a frame. While select is held low, each group of eight clocks shifts that byte out most significant bit first and shifts the controller's byte in. The incoming byte then overwrites the data register, a completion flag rises and, if enabled, an interrupt line follows the flag.

All three link inputs are brought into the system clock domain through a two-flop synchroniser, and every clock edge is found there, so the link clock may run at most one quarter of the system clock rate. Four clock modes are supported: idle level and sampling edge are chosen in the control register. A typical use is a loop in which software reads each received byte and writes it back, so the controller sees each of its bytes returned one frame later.

Top module: `spi_tgt_periph`

## Requirements
- R1: Registers sit at bus address 0 (control), 1 (interrupt enable, bit 0), 2 (status, completion flag in bit 7) and 3 (data); all read as zero after reset, and a read returns the addressed register on `reg_rdata` in the same cycle as `reg_rd`.
- R2: The target is active only when control bit 6 is set and control bit 4 is clear; control bits 3:2 hold the clock mode (bit 3 = clock idles high, bit 2 = sample on the trailing edge), so 0x40 selects an active target in mode 0. With bit 4 set, a full frame leaves the flag and the data register unchanged.
- R3: While `ss_n` is high, clock and data-in transitions are ignored: no flag, no change of the data register, and `miso_oe` is low three system clocks after `ss_n` has been high.
- R4: The byte held in the data register before a frame is driven on `miso`, most significant bit first, and is valid at every sampling edge in all four modes.
- R5: After eight sampling edges with `ss_n` low, the received byte (first bit is the most significant) replaces the data register and the completion flag is set.
- R6: The flag clears only on a data register read or write that follows a status read made while the flag was set; a data access without that prior status read leaves it set.
- R7: `irq` is high exactly when the completion flag and the interrupt enable bit are both set.
- R8: Raising `ss_n` in the middle of a byte discards the partial byte without setting the flag, and the next frame starts again from the most significant bit.
- R9: In modes 0 and 2 the first reply bit is on `miso` as soon as `ss_n` falls; in modes 1 and 3 `miso` keeps its old level until the first leading clock edge.
- R10: When software writes each received byte back, a controller that sends one more than each byte it receives (starting from 1) sees the reply sequence 00, 01, 01, 02, 02, 03.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data |
| irq | output | 1 | Completion interrupt |
| sck | input | 1 | Link clock from the controller |
| mosi | input | 1 | Data from the controller |
| ss_n | input | 1 | Active-low select |
| miso | output | 1 | Reply data to the controller |
| miso_oe | output | 1 | Output enable for the reply line |

## Verification
The assertions assume the link clock stays at least four system clocks in each level, so every edge passes the synchroniser alone and the data-in line is settled when its edge is seen, and that select only changes while the clock rests at its idle level. The stimulus drives every link pin on falling system-clock edges with four-cycle half periods, lowers select four cycles before the first clock edge and raises it four cycles after the last one, and changes the mode only with select high.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;

    typedef enum logic [1:0] {
        A_CTRL = 2'd0,
        A_IRQ  = 2'd1,
        A_STAT = 2'd2,
        A_DATA = 2'd3
    } reg_sel_e;

    localparam int CTRL_ON   = 6;
    localparam int CTRL_HOST = 4;
    localparam int CTRL_CPOL = 3;
    localparam int CTRL_CPHA = 2;
    localparam int STAT_DONE = 7;

endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
    parameter int            N       = 1,
    parameter int            STAGES  = 2,
    parameter logic [N-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);

    logic [STAGES-1:0][N-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/spi_tgt_shift.sv
module spi_tgt_shift #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          cpol_i,
    input  logic          cpha_i,
    input  logic          sck_i,
    input  logic          mosi_i,
    input  logic          ss_n_i,
    input  logic [DW-1:0] tx_i,
    output logic          done_o,
    output logic [DW-1:0] rx_o,
    output logic          miso_o,
    output logic          miso_oe_o
);

    localparam int            CW   = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [CW-1:0] LAST = CW'(DW - 1);

    typedef struct packed {
        logic          sck_prev;
        logic          act;
        logic [CW-1:0] cnt;
        logic [DW-1:0] txb;
        logic [DW-1:0] rxb;
        logic [DW-1:0] rxw;
        logic          miso;
        logic          oe;
        logic          done;
    } shift_st_t;

    shift_st_t s_d, s_q;
    logic rise, fall, lead, trail, samp, shft;
    logic [DW-1:0] cur;

    always_comb begin
        rise  = sck_i & ~s_q.sck_prev;
        fall  = ~sck_i & s_q.sck_prev;
        lead  = cpol_i ? fall : rise;
        trail = cpol_i ? rise : fall;
        samp  = cpha_i ? trail : lead;
        shft  = cpha_i ? lead : trail;
        cur   = s_q.act ? s_q.txb : tx_i;

        s_d          = s_q;
        s_d.sck_prev = sck_i;
        s_d.done     = 1'b0;
        s_d.oe       = en_i & ~ss_n_i;

        if (!en_i || ss_n_i) begin
            // idle or aborted: drop any partial byte
            s_d.act = 1'b0;
            s_d.cnt = '0;
            s_d.rxb = '0;
            s_d.txb = tx_i;
            if (!cpha_i) s_d.miso = tx_i[DW-1];
        end else begin
            // between bytes the shifter follows the data register
            if (!s_q.act) begin
                s_d.txb = tx_i;
                if (!cpha_i) s_d.miso = tx_i[DW-1];
            end
            if (shft && cpha_i) begin
                s_d.miso = cur[DW-1];
                s_d.txb  = cur << 1;
                s_d.act  = 1'b1;
            end else if (shft && s_q.act) begin
                s_d.miso = s_q.txb[DW-2];
                s_d.txb  = s_q.txb << 1;
            end
            if (samp && (s_q.act || !cpha_i)) begin
                s_d.rxb = {s_q.rxb[DW-2:0], mosi_i};
                if (s_q.cnt == LAST) begin
                    s_d.done = 1'b1;
                    s_d.rxw  = {s_q.rxb[DW-2:0], mosi_i};
                    s_d.cnt  = '0;
                    s_d.act  = 1'b0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                    s_d.act = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign done_o    = s_q.done;
    assign rx_o      = s_q.rxw;
    assign miso_o    = s_q.miso;
    assign miso_oe_o = s_q.oe;

    // R5 / R3: a byte can only complete while selected and enabled
    a_r5_done_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(!ss_n_i && en_i));

    // R8: an abort leaves the engine at bit zero on the next cycle
    a_r8_abort_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_n_i && s_q.cnt != '0) |=> (s_q.cnt == '0 && !done_o));

endmodule

// File: rtl/spi_tgt_regs.sv
module spi_tgt_regs
    import spi_tgt_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic          rd_i,
    input  logic [1:0]    addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          done_i,
    input  logic [DW-1:0] rx_i,
    output logic [DW-1:0] rdata_o,
    output logic [DW-1:0] data_o,
    output logic          en_o,
    output logic          cpol_o,
    output logic          cpha_o,
    output logic          irq_o
);

    typedef struct packed {
        logic [DW-1:0] ctrl;
        logic          ie;
        logic [DW-1:0] data;
        logic          flag;
        logic          armed;
    } reg_st_t;

    reg_st_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_i) begin
            unique case (addr_i)
                A_CTRL:  r_d.ctrl = wdata_i;
                A_IRQ:   r_d.ie   = wdata_i[0];
                A_DATA:  r_d.data = wdata_i;
                default: ;
            endcase
        end
        if (rd_i && addr_i == A_STAT && r_q.flag) r_d.armed = 1'b1;
        if ((rd_i || wr_i) && addr_i == A_DATA && r_q.armed) begin
            r_d.flag  = 1'b0;
            r_d.armed = 1'b0;
        end
        if (done_i) begin
            r_d.data  = rx_i;
            r_d.flag  = 1'b1;
            r_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata_o = '0;
        if (rd_i) begin
            unique case (addr_i)
                A_CTRL:  rdata_o = r_q.ctrl;
                A_IRQ:   rdata_o[0] = r_q.ie;
                A_STAT:  rdata_o[STAT_DONE] = r_q.flag;
                default: rdata_o = r_q.data;
            endcase
        end
    end

    assign data_o = r_q.data;
    assign en_o   = r_q.ctrl[CTRL_ON] & ~r_q.ctrl[CTRL_HOST];
    assign cpol_o = r_q.ctrl[CTRL_CPOL];
    assign cpha_o = r_q.ctrl[CTRL_CPHA];
    assign irq_o  = r_q.flag & r_q.ie;

    // R5: completion sets the flag and loads the received byte
    a_r5_flag_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> r_q.flag);
    a_r5_data_takes_rx: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> (r_q.data == $past(rx_i)));

    // R6: the flag only rises on completion and only falls after a status read
    a_r6_flag_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.flag) |-> $past(done_i));
    a_r6_flag_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.flag) |-> $past(r_q.armed && addr_i == A_DATA));

endmodule

// File: rtl/spi_tgt_periph.sv
module spi_tgt_periph
    import spi_tgt_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq,
    input  logic          sck,
    input  logic          mosi,
    input  logic          ss_n,
    output logic          miso,
    output logic          miso_oe
);

    localparam int RUNW = $clog2(SYNC_STAGES + 2);
    localparam logic [RUNW-1:0] RUN_MAX = RUNW'(SYNC_STAGES);

    logic [2:0]    pins_s;
    logic          en, cpol, cpha, done;
    logic [DW-1:0] data, rx;

    spi_tgt_sync #(
        .N       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ss_n, mosi, sck}),
        .sync_o  (pins_s)
    );

    spi_tgt_regs #(.DW(DW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr),
        .rd_i    (reg_rd),
        .addr_i  (reg_addr),
        .wdata_i (reg_wdata),
        .done_i  (done),
        .rx_i    (rx),
        .rdata_o (reg_rdata),
        .data_o  (data),
        .en_o    (en),
        .cpol_o  (cpol),
        .cpha_o  (cpha),
        .irq_o   (irq)
    );

    spi_tgt_shift #(.DW(DW)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en),
        .cpol_i    (cpol),
        .cpha_i    (cpha),
        .sck_i     (pins_s[0]),
        .mosi_i    (pins_s[1]),
        .ss_n_i    (pins_s[2]),
        .tx_i      (data),
        .done_o    (done),
        .rx_o      (rx),
        .miso_o    (miso),
        .miso_oe_o (miso_oe)
    );

    // run length of select held high at the pin, for the R3 check
    logic [RUNW-1:0] ss_run_d, ss_run_q;

    always_comb begin
        ss_run_d = ss_run_q;
        if (!ss_n)                  ss_run_d = '0;
        else if (ss_run_q < RUN_MAX) ss_run_d = ss_run_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ss_run_q <= '0;
        else        ss_run_q <= ss_run_d;
    end

    // R3: once select has been high through the synchroniser, the line is released
    a_r3_release_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_n && ss_run_q >= RUN_MAX) |=> !miso_oe);

    // R7: no interrupt without a completed byte since reset
    a_r7_irq_needs_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(done) || $past(reg_wr && reg_addr == A_IRQ)));

endmodule

// File: tb/spi_tgt_periph_tb.sv
`timescale 1ns/1ps
module spi_tgt_periph_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq;
    logic       sck = 1'b0, mosi = 1'b0, ss_n = 1'b1;
    logic       miso, miso_oe;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  ended = 1'b0;
    bit  cmp_on = 1'b0;

    always #5 clk = ~clk;

    spi_tgt_periph dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .sck(sck), .mosi(mosi), .ss_n(ss_n),
        .miso(miso), .miso_oe(miso_oe)
    );

    // per-clock reference for the reply enable: select delayed through two stages
    logic ss_h0 = 1'b1, ss_h1 = 1'b1, ss_h2 = 1'b1, en_m = 1'b0, exp_oe = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            ss_h0 = 1'b1; ss_h1 = 1'b1; ss_h2 = 1'b1; en_m = 1'b0; exp_oe = 1'b0;
        end else begin
            ss_h2 = ss_h1; ss_h1 = ss_h0; ss_h0 = ss_n;
            exp_oe = en_m & ~ss_h2;
            if (reg_wr && reg_addr == 2'd0) en_m = reg_wdata[6] & ~reg_wdata[4];
        end
    end

    always @(negedge clk) begin
        if (rst_n && cmp_on && !ended) begin
            n_cmp++;
            if (miso_oe !== exp_oe) begin
                n_bad++;
                $display("FAIL R3 miso_oe per-clock: actual=%0b expected=%0b at %0t", miso_oe, exp_oe, $time);
            end
        end
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R10 watchdog: actual=running expected=finished");
        finish_run();
    end

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        #1 v = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic select(input logic lvl);
        @(negedge clk); ss_n = lvl;
        idle(4);
    endtask

    task automatic set_mode(input int m);
        wr(2'd0, 8'h40 | 8'(m << 2));
        @(negedge clk); sck = m[1];
        idle(4);
    endtask

    // controller side: half period of four system clocks
    task automatic frame(input int m, input logic [7:0] mo, input int nbits, output logic [7:0] mi);
        logic cpol, cpha;
        cpol = m[1]; cpha = m[0];
        mi = 8'h00;
        for (int i = 0; i < nbits; i++) begin
            if (!cpha) mosi = mo[7-i];
            idle(4);
            if (!cpha) mi[7-i] = miso;
            sck = ~cpol;
            if (cpha) mosi = mo[7-i];
            idle(4);
            if (cpha) mi[7-i] = miso;
            sck = cpol;
        end
        idle(4);
    endtask

    initial begin
        logic [7:0] v, r;
        logic [7:0] sl [3] = '{8'h5A, 8'hC3, 8'h81};
        logic [7:0] ms [3] = '{8'h69, 8'h17, 8'hFE};
        logic [7:0] seq [6] = '{8'h00, 8'h01, 8'h01, 8'h02, 8'h02, 8'h03};
        logic [7:0] hold, mtx, mrx_prev;

        idle(5);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        idle(2);

        // R1 reset state
        rd(2'd0, v); chk("R1", "ctrl after reset", v, 8'h00);
        rd(2'd1, v); chk("R1", "irq enable after reset", v, 8'h00);
        rd(2'd2, v); chk("R1", "status after reset", v, 8'h00);
        rd(2'd3, v); chk("R1", "data after reset", v, 8'h00);
        chk("R7", "irq after reset", {7'd0, irq}, 8'h00);

        // R2 mode 0 configuration
        wr(2'd0, 8'h40);
        rd(2'd0, v); chk("R2", "ctrl readback", v, 8'h40);

        // mode 0 frame, R9 first bit at select fall
        wr(2'd3, 8'hA5);
        select(1'b0);
        chk("R9", "mode0 bit7 at select fall", {6'd0, miso_oe, miso}, 8'h03);
        frame(0, 8'h3C, 8, r);
        select(1'b1);
        chk("R4", "mode0 reply", r, 8'hA5);
        chk("R7", "irq with enable off", {7'd0, irq}, 8'h00);
        wr(2'd1, 8'h01);
        chk("R7", "irq with enable on", {7'd0, irq}, 8'h01);

        // R6 clear sequence
        rd(2'd3, v); chk("R5", "mode0 received byte", v, 8'h3C);
        rd(2'd2, v); chk("R6", "flag kept after bare data read", v, 8'h80);
        wr(2'd3, 8'h96);
        rd(2'd2, v); chk("R6", "flag cleared by data write", v, 8'h00);
        chk("R7", "irq after clear", {7'd0, irq}, 8'h00);

        // other modes
        for (int m = 1; m < 4; m++) begin
            set_mode(m);
            wr(2'd3, sl[m-1]);
            select(1'b0);
            frame(m, ms[m-1], 8, r);
            select(1'b1);
            chk("R4", $sformatf("mode%0d reply", m), r, sl[m-1]);
            rd(2'd2, v); chk("R5", $sformatf("mode%0d flag", m), v, 8'h80);
            rd(2'd3, v); chk("R5", $sformatf("mode%0d received", m), v, ms[m-1]);
            rd(2'd2, v); chk("R6", $sformatf("mode%0d flag cleared by read", m), v, 8'h00);
            if (m == 1) begin
                // previous last bit was 0; new first bit 1 must wait for the leading edge
                wr(2'd3, 8'h80);
                select(1'b0);
                chk("R9", "mode1 line held before leading edge", {7'd0, miso}, 8'h00);
                frame(1, 8'h44, 8, r);
                select(1'b1);
                chk("R9", "mode1 first bit at leading edge", r, 8'h80);
                rd(2'd2, v);
                rd(2'd3, v); chk("R5", "mode1 second received", v, 8'h44);
            end
        end

        // R3 select high: everything ignored
        set_mode(0);
        wr(2'd3, 8'h11);
        frame(0, 8'hEE, 8, r);
        rd(2'd2, v); chk("R3", "flag with select high", v, 8'h00);
        rd(2'd3, v); chk("R3", "data with select high", v, 8'h11);

        // R8 abort mid-byte
        select(1'b0);
        frame(0, 8'hF0, 5, r);
        select(1'b1);
        rd(2'd2, v); chk("R8", "flag after abort", v, 8'h00);
        rd(2'd3, v); chk("R8", "data after abort", v, 8'h11);
        select(1'b0);
        frame(0, 8'h3B, 8, r);
        select(1'b1);
        chk("R8", "reply restarts at bit7", r, 8'h11);
        rd(2'd2, v);
        rd(2'd3, v); chk("R8", "full byte after abort", v, 8'h3B);

        // R2 controller-select bit set: target inactive
        wr(2'd0, 8'h50);
        wr(2'd3, 8'h22);
        select(1'b0);
        frame(0, 8'h99, 8, r);
        select(1'b1);
        rd(2'd2, v); chk("R2", "flag while inactive", v, 8'h00);
        rd(2'd3, v); chk("R2", "data while inactive", v, 8'h22);

        // R10 echo loop against an incrementing controller
        wr(2'd0, 8'h40);
        wr(2'd3, 8'h00);
        hold = 8'h00;
        mrx_prev = 8'h00;
        for (int i = 0; i < 6; i++) begin
            mtx = mrx_prev + 8'h01;
            select(1'b0);
            frame(0, mtx, 8, r);
            select(1'b1);
            chk("R10", $sformatf("echo frame %0d model", i), r, hold);
            chk("R10", $sformatf("echo frame %0d sequence", i), r, seq[i]);
            rd(2'd2, v);
            rd(2'd3, v); chk("R5", $sformatf("echo frame %0d received", i), v, mtx);
            wr(2'd3, v);
            hold = mtx;
            mrx_prev = r;
        end

        idle(8);
        finish_run();
    end

endmodule